// File: doc/BRIEF.md
# Boot Mode Selection Controller

This controller runs once after every reset and decides where the device goes next. There are three possible targets: the user program, an ISP command handler bound to one serial interface, or an ISP handler that probes all three serial interfaces to find the one in use. It also tells the clock generator whether to start at the normal 12 MHz rate or at the 1.5 MHz low-power rate.

The inputs are latched together in the first clock cycle after reset is released. They are the ISP entry pin (active low), the flag that disables sampling of that pin, the user-code-valid flag, the two validity bits of the stored configuration, the stored 2-bit interface select and the stored low-power-start bit. The decision is made in priority order. An ISP request from the pin is checked first. User-code validity is checked next. The stored interface choice is used last. In the second cycle after reset release the result is registered and a one-cycle done strobe is raised. The result then does not change until the next reset.

Top module: `boot_select`

## Requirements
- R1: While reset is held, boot_target is 3'b000, isp_if is 2'b00, start_slow is 0 and done is 0. boot_target is still 3'b000 in the first cycle after reset release.
- R2: When pin_ignore is 0 and isp_pin_n is sampled low, the controller takes an ISP path (boot_target bit1 or bit2), even when code_valid is 1.
- R3: When pin_ignore is 1, the level on isp_pin_n has no effect. With code_valid 1 the target is user code.
- R4: When there is no ISP request and code_valid is 1, boot_target is 3'b001 (bit0 = user code) and isp_if is 2'b00.
- R5: On an ISP path with a valid configuration and cfg_if not 2'b11, boot_target is 3'b010 (bit1 = fixed handler) and isp_if equals cfg_if (00 UART, 01 I2C, 10 SPI).
- R6: The configuration is valid only when both bits of cfg_valid are 1. On an ISP path with any other value, boot_target is 3'b100 (bit2 = auto-detect) and isp_if is 2'b11.
- R7: On an ISP path with a valid configuration and cfg_if = 2'b11, the controller selects auto-detect: boot_target 3'b100 and isp_if 2'b11.
- R8: start_slow is 1 (1.5 MHz start) only when the configuration is valid and cfg_lowpwr is 1. Otherwise it is 0 (12 MHz), whatever the boot target.
- R9: done is 1 for exactly one cycle, in the second cycle after reset release. The outputs hold their final values from that cycle onward.
- R10: All inputs are sampled only at the first clock edge after reset release. Later changes leave every output unchanged until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| isp_pin_n | input | 1 | ISP entry pin, low requests ISP |
| pin_ignore | input | 1 | 1 disables sampling of the ISP pin |
| code_valid | input | 1 | Valid user code present |
| cfg_valid | input | 2 | Stored configuration validity bits, valid only when 2'b11 |
| cfg_if | input | 2 | Stored ISP interface select |
| cfg_lowpwr | input | 1 | Stored low-power start bit |
| boot_target | output | 3 | One-hot target: bit0 user, bit1 fixed ISP, bit2 auto ISP |
| isp_if | output | 2 | Chosen interface, 2'b11 for auto-detect |
| start_slow | output | 1 | 1 = 1.5 MHz start, 0 = 12 MHz |
| done | output | 1 | One-cycle pulse when the decision is registered |

## Verification
Inputs are captured at the first rising edge after reset release, and the outputs and done change at the second. The bench releases reset on a falling edge. It checks for an empty target after the first edge, then checks the full decision and the done pulse after the second edge. It then scrambles every input and checks, after the third edge, that done has dropped and that the outputs have not moved. All sampling happens on falling edges, half a period away from the edges at which the design updates.

// File: rtl/boot_select.sv
module boot_select (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       isp_pin_n,
  input  logic       pin_ignore,
  input  logic       code_valid,
  input  logic [1:0] cfg_valid,
  input  logic [1:0] cfg_if,
  input  logic       cfg_lowpwr,
  output logic [2:0] boot_target,
  output logic [1:0] isp_if,
  output logic       start_slow,
  output logic       done
);

  localparam logic [2:0] TGT_USER  = 3'b001;
  localparam logic [2:0] TGT_FIXED = 3'b010;
  localparam logic [2:0] TGT_AUTO  = 3'b100;
  localparam logic [1:0] IF_AUTO   = 2'b11;

  typedef enum logic [1:0] {S_SAMPLE, S_DECIDE, S_HOLD} state_t;
  state_t state;

  logic       pin_q, ign_q, code_q, lp_q;
  logic [1:0] vld_q, sel_q;

  logic cfg_ok, isp_req, go_isp, use_fixed;
  logic [2:0] tgt_next;
  logic [1:0] if_next;

  assign cfg_ok    = (vld_q == 2'b11);
  assign isp_req   = !ign_q && !pin_q;
  assign go_isp    = isp_req || !code_q;
  assign use_fixed = cfg_ok && (sel_q != IF_AUTO);
  assign tgt_next  = !go_isp ? TGT_USER : (use_fixed ? TGT_FIXED : TGT_AUTO);
  assign if_next   = !go_isp ? 2'b00 : (use_fixed ? sel_q : IF_AUTO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_SAMPLE;
      pin_q       <= 1'b1;
      ign_q       <= 1'b0;
      code_q      <= 1'b0;
      lp_q        <= 1'b0;
      vld_q       <= 2'b00;
      sel_q       <= 2'b00;
      boot_target <= '0;
      isp_if      <= '0;
      start_slow  <= 1'b0;
      done        <= 1'b0;
    end else begin
      case (state)
        S_SAMPLE: begin
          pin_q  <= isp_pin_n;
          ign_q  <= pin_ignore;
          code_q <= code_valid;
          vld_q  <= cfg_valid;
          sel_q  <= cfg_if;
          lp_q   <= cfg_lowpwr;
          state  <= S_DECIDE;
        end
        S_DECIDE: begin
          boot_target <= tgt_next;
          isp_if      <= if_next;
          start_slow  <= cfg_ok && lp_q;
          done        <= 1'b1;
          state       <= S_HOLD;
        end
        default: done <= 1'b0;
      endcase
    end
  end

  a_r1_target_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(boot_target));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_has_target: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones(boot_target) == 1);

  a_r10_outputs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_target != 3'b000) |=> $stable(boot_target) && $stable(isp_if) && $stable(start_slow));

  a_r6_auto_iface: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_target == TGT_AUTO) |-> isp_if == IF_AUTO);

  a_r5_fixed_iface: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_target == TGT_FIXED) |-> isp_if != IF_AUTO);

  a_r4_user_iface: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_target == TGT_USER) |-> isp_if == 2'b00);

endmodule

// File: tb/sim_boot_select.sv
module sim_boot_select;
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0;
  logic isp_pin_n = 1, pin_ignore = 0, code_valid = 0, cfg_lowpwr = 0;
  logic [1:0] cfg_valid = 0, cfg_if = 0;
  logic [2:0] boot_target;
  logic [1:0] isp_if;
  logic start_slow, done;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(TCLK/2) clk = ~clk;

  boot_select u0 (.clk, .rst_n, .isp_pin_n, .pin_ignore, .code_valid,
                  .cfg_valid, .cfg_if, .cfg_lowpwr,
                  .boot_target, .isp_if, .start_slow, .done);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(string req, logic pin, logic ign, logic cv, logic [1:0] vld,
                     logic [1:0] sel, logic lp,
                     logic [2:0] e_tgt, logic [1:0] e_if, logic e_slow);
    @(negedge clk);
    rst_n = 0;
    isp_pin_n = pin; pin_ignore = ign; code_valid = cv;
    cfg_valid = vld; cfg_if = sel; cfg_lowpwr = lp;
    @(negedge clk);
    chk({req, " R1 reset target"}, {5'b0, boot_target}, 8'h00);
    chk({req, " R1 reset done"}, {7'b0, done}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk({req, " R1 empty before decision"}, {4'b0, done, boot_target}, 8'h00);
    isp_pin_n = ~pin; pin_ignore = ~ign; code_valid = ~cv;
    cfg_valid = ~vld; cfg_if = ~sel; cfg_lowpwr = ~lp;
    @(negedge clk);
    chk({req, " R9 done pulse"}, {7'b0, done}, 8'h01);
    chk({req, " target"}, {5'b0, boot_target}, {5'b0, e_tgt});
    chk({req, " iface"}, {6'b0, isp_if}, {6'b0, e_if});
    chk({req, " R8 clock"}, {7'b0, start_slow}, {7'b0, e_slow});
    @(negedge clk);
    chk({req, " R9 done drops"}, {7'b0, done}, 8'h00);
    chk({req, " R10 held"}, {2'b0, start_slow, isp_if, boot_target},
        {2'b0, e_slow, e_if, e_tgt});
  endtask

  task automatic t_user();     run("R4 user code", 1, 0, 1, 2'b11, 2'b10, 1, 3'b001, 2'b00, 1); endtask
  task automatic t_pin_req();  run("R2 pin request", 0, 0, 1, 2'b11, 2'b01, 0, 3'b010, 2'b01, 0); endtask
  task automatic t_pin_ign();  run("R3 pin ignored", 0, 1, 1, 2'b11, 2'b10, 0, 3'b001, 2'b00, 0); endtask
  task automatic t_nocode();   run("R5 uart", 1, 0, 0, 2'b11, 2'b00, 1, 3'b010, 2'b00, 1); endtask
  task automatic t_spi();      run("R5 spi", 1, 1, 0, 2'b11, 2'b10, 0, 3'b010, 2'b10, 0); endtask
  task automatic t_inv01();    run("R6 invalid 01", 1, 0, 0, 2'b01, 2'b01, 1, 3'b100, 2'b11, 0); endtask
  task automatic t_inv10();    run("R6 invalid 10", 0, 0, 1, 2'b10, 2'b00, 1, 3'b100, 2'b11, 0); endtask
  task automatic t_reserved(); run("R7 reserved sel", 0, 0, 0, 2'b11, 2'b11, 1, 3'b100, 2'b11, 1); endtask
  task automatic t_inv_user(); run("R8 invalid cfg user", 1, 0, 1, 2'b00, 2'b00, 1, 3'b001, 2'b00, 0); endtask

  initial begin
    t_user(); t_pin_req(); t_pin_ign(); t_nocode(); t_spi();
    t_inv01(); t_inv10(); t_reserved(); t_inv_user();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule